// File: doc/BRIEF.md
# Host Transfer Queue with Single-Byte Fallback

This block sits between the host bus and the disk data path of a disk controller. Bytes move through one shared queue. In a write-direction phase the host fills it and the disk side drains it. In a read-direction phase the disk side fills it and the host drains it. The block reports through a ready-for-master bit, a DMA service request and queue occupancy flags. Command decoding and serialisation are handled elsewhere; this block only stores bytes and decides when each side may move the next one.

After hardware reset the queue acts as a one-byte holding register, so software written for byte-at-a-time handshaking sees the behaviour it expects. A configure strobe can turn on queuing and set a service threshold. Even then, the queue keeps its one-byte behaviour while the controller is in the command and result phases. It only accepts bursts during the execution phase. When the execution phase ends, any bytes left in the queue are discarded.

Top module: `xfer_fifo`

## Requirements
- R1: While reset (`rst_n` low) is asserted and directly after it, queuing is off, the threshold code is 0, `q_empty` is 1, `q_full`, `dma_req` and `xfer_err` are 0, and `rqm` is 0 in the idle phase.
- R2: With queuing off, the queue holds at most one byte in every phase. `q_full` rises after one accepted byte.
- R3: A cycle with `cfg_we` high loads `cfg_fifo_en` as the queuing enable and `cfg_thr_code` as a threshold of code+1 (code 0..15 gives 1..16). Only reset changes these values otherwise.
- R4: With queuing on, the command phase (`phase`=00) and the result phase (`phase`=10) still hold at most one byte.
- R5: With queuing on, the execution phase (`phase`=01) accepts up to 16 bytes before `q_full` rises.
- R6: `rqm` is `!q_full` in write-direction phases and `!q_empty` in read-direction phases. It is 0 in idle (`phase`=11).
- R7: `dma_req` is registered and is 0 outside the execution phase. In byte mode it reflects whether one byte is available to move. In burst mode it is set when free space (host-to-disk) or stored bytes (disk-to-host) reaches the threshold. It then holds until the queue is full or empty, respectively.
- R8: The first cycle outside the execution phase after being in it clears the queue, so `q_empty` is 1 afterwards.
- R9: A host write while `q_full` is set in a write-direction phase, or a host read while `q_empty` is set in a read-direction phase, sets sticky `xfer_err` and leaves the queue unchanged. Only reset clears `xfer_err`.
- R10: The command phase is host-to-disk and the result phase is disk-to-host. In the execution phase, `exec_to_host`=1 selects disk-to-host. Host strobes have no effect in the idle phase.
- R11: Bytes leave in arrival order. `host_rdata` and `dsk_rdata` both show the oldest stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_we | input | 1 | Configure strobe |
| cfg_fifo_en | input | 1 | Queuing enable value to load |
| cfg_thr_code | input | 4 | Threshold minus one |
| phase | input | 2 | Controller phase: 00 command, 01 execution, 10 result, 11 idle |
| exec_to_host | input | 1 | Execution-phase direction, 1 = disk to host |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Oldest stored byte for the host |
| dsk_push | input | 1 | Disk-side write strobe |
| dsk_wdata | input | 8 | Disk-side write byte |
| dsk_pop | input | 1 | Disk-side read strobe |
| dsk_rdata | output | 8 | Oldest stored byte for the disk side |
| rqm | output | 1 | Ready for the host to move one byte |
| dma_req | output | 1 | DMA service request |
| q_empty | output | 1 | Queue holds no byte |
| q_full | output | 1 | Queue at its present capacity |
| xfer_err | output | 1 | Sticky overrun/underrun flag |

## Verification
The hardest state to reach is the hold band of the burst request. After a full queue has cleared the request, draining must not re-raise it until free space reaches the threshold again. The bench fills all sixteen entries with queuing on and a threshold of four. It then pops one byte at a time and checks that the request stays low for three pops and returns on the fourth. A second run with threshold sixteen in the disk-to-host direction checks the top boundary, and a forced read from an empty queue at the end of that run raises the error flag.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;
    typedef enum logic [1:0] {
        PH_CMD  = 2'b00,
        PH_EXEC = 2'b01,
        PH_RES  = 2'b10,
        PH_IDLE = 2'b11
    } phase_e;
endpackage

// File: rtl/xfer_fifo_ram.sv
module xfer_fifo_ram #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (we && waddr == PW'(i)) mem_q[i] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/xfer_fifo_dreq.sv
module xfer_fifo_dreq #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_exec,
    input  logic          burst,
    input  logic          to_host,
    input  logic [CW-1:0] cnt_d,
    input  logic [CW-1:0] thr,
    output logic          dma_req
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic req_d, req_q;
    logic [CW-1:0] space_d;

    always_comb begin
        space_d = DEPTH_C - cnt_d;
        req_d   = req_q;
        if (!in_exec) begin
            req_d = 1'b0;
        end else if (!burst) begin
            req_d = to_host ? (cnt_d != '0) : (cnt_d == '0);
        end else if (to_host) begin
            if (cnt_d >= thr)       req_d = 1'b1;
            else if (cnt_d == '0)   req_d = 1'b0;
        end else begin
            if (space_d >= thr)        req_d = 1'b1;
            else if (cnt_d == DEPTH_C) req_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req_d;
    end

    assign dma_req = req_q;
endmodule

// File: rtl/xfer_fifo.sv
module xfer_fifo
    import xfer_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_fifo_en,
    input  logic [TW-1:0] cfg_thr_code,
    input  logic [1:0]    phase,
    input  logic          exec_to_host,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    input  logic          dsk_push,
    input  logic [DW-1:0] dsk_wdata,
    input  logic          dsk_pop,
    output logic [DW-1:0] dsk_rdata,
    output logic          rqm,
    output logic          dma_req,
    output logic          q_empty,
    output logic          q_full,
    output logic          xfer_err
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    typedef struct packed {
        logic          en;
        logic [TW-1:0] thr_code;
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
        logic          err;
        phase_e        ph_prev;
    } st_t;

    st_t st_d, st_q;

    phase_e        ph;
    logic          burst, wdir, rdir, full, empty, flush;
    logic          do_push, do_pop;
    logic [CW-1:0] cap, thr;
    logic [DW-1:0] wdata, head;

    function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ph    = phase_e'(phase);
        burst = st_q.en && (ph == PH_EXEC);
        cap   = burst ? DEPTH_C : CW'(1);
        thr   = CW'(st_q.thr_code) + CW'(1);
        wdir  = (ph == PH_CMD) || ((ph == PH_EXEC) && !exec_to_host);
        rdir  = (ph == PH_RES) || ((ph == PH_EXEC) && exec_to_host);
        full  = st_q.cnt >= cap;
        empty = st_q.cnt == '0;
        flush = (st_q.ph_prev == PH_EXEC) && (ph != PH_EXEC);

        do_push = !flush && !full  && ((wdir && host_wr) || (rdir && dsk_push));
        do_pop  = !flush && !empty && ((rdir && host_rd) || (wdir && dsk_pop));
        wdata   = wdir ? host_wdata : dsk_wdata;

        st_d         = st_q;
        st_d.ph_prev = ph;
        st_d.err     = st_q.err | (wdir && host_wr && full) | (rdir && host_rd && empty);
        if (cfg_we) begin
            st_d.en       = cfg_fifo_en;
            st_d.thr_code = cfg_thr_code;
        end
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) st_d.wp = inc_ptr(st_q.wp);
            if (do_pop)  st_d.rp = inc_ptr(st_q.rp);
            st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, thr_code: '0, wp: '0, rp: '0, cnt: '0,
                      err: 1'b0, ph_prev: PH_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    xfer_fifo_ram #(.DEPTH(DEPTH), .DW(DW)) ram_i (
        .clk   (clk),
        .we    (do_push),
        .waddr (st_q.wp),
        .wdata (wdata),
        .raddr (st_q.rp),
        .rdata (head)
    );

    xfer_fifo_dreq #(.DEPTH(DEPTH)) dreq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_exec (ph == PH_EXEC),
        .burst   (burst),
        .to_host (exec_to_host),
        .cnt_d   (st_d.cnt),
        .thr     (thr),
        .dma_req (dma_req)
    );

    assign host_rdata = head;
    assign dsk_rdata  = head;
    assign q_empty    = empty;
    assign q_full     = full;
    assign xfer_err   = st_q.err;
    assign rqm        = wdir ? !full : (rdir ? !empty : 1'b0);
endmodule

// File: rtl/xfer_fifo_chk.sv
module xfer_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] phase,
    input logic       host_wr,
    input logic       rqm,
    input logic       dma_req,
    input logic       q_empty,
    input logic       q_full,
    input logic       xfer_err
);
    logic [1:0] ph_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_seen_q <= 2'b11;
        else        ph_seen_q <= phase;
    end

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_err |=> xfer_err);

    a_r9_cmd_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && q_full && phase == 2'b00) |=> xfer_err);

    a_r4_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'b01 && !q_empty) |-> q_full);

    a_r6_idle_no_rqm: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'b11) |-> !rqm);

    a_r7_dreq_exec_only: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != 2'b01) |=> !dma_req);

    a_r8_flush_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_seen_q == 2'b01 && phase != 2'b01) |=> q_empty);

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));
endmodule

bind xfer_fifo xfer_fifo_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .host_wr  (host_wr),
    .rqm      (rqm),
    .dma_req  (dma_req),
    .q_empty  (q_empty),
    .q_full   (q_full),
    .xfer_err (xfer_err)
);

// File: tb/xfer_fifo_tb_top.sv
`timescale 1ns/1ps
module xfer_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_fifo_en = 1'b0;
    logic [3:0] cfg_thr_code = '0;
    logic [1:0] phase = 2'b11;
    logic       exec_to_host = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, dsk_push = 1'b0, dsk_pop = 1'b0;
    logic [7:0] host_wdata = '0, dsk_wdata = '0;
    logic [7:0] host_rdata, dsk_rdata;
    logic       rqm, dma_req, q_empty, q_full, xfer_err;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    xfer_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_fifo_en(cfg_fifo_en),
        .cfg_thr_code(cfg_thr_code), .phase(phase), .exec_to_host(exec_to_host),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .dsk_push(dsk_push), .dsk_wdata(dsk_wdata),
        .dsk_pop(dsk_pop), .dsk_rdata(dsk_rdata), .rqm(rqm), .dma_req(dma_req),
        .q_empty(q_empty), .q_full(q_full), .xfer_err(xfer_err)
    );

    typedef struct packed {
        logic [1:0] ph;
        logic       x2h, hwr, hrd, dpush, dpop;
        logic [7:0] din;
        logic       rqm, dreq, emp, ful, err;
        logic [7:0] head;
    } vec_t;

    // byte-mode walk (queuing off): R2 R6 R7 R8 R10 R11
    localparam vec_t VEC [12] = '{
        '{2'b00,1'b0,1'b1,1'b0,1'b0,1'b0,8'hA1, 1'b0,1'b0,1'b0,1'b1,1'b0,8'hA1},
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b1,1'b0,1'b0,8'h00},
        '{2'b10,1'b0,1'b0,1'b0,1'b1,1'b0,8'h5C, 1'b1,1'b0,1'b0,1'b1,1'b0,8'h5C},
        '{2'b10,1'b0,1'b0,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,8'h00},
        '{2'b11,1'b0,1'b1,1'b0,1'b0,1'b0,8'h77, 1'b0,1'b0,1'b1,1'b0,1'b0,8'h00},
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b1,1'b1,1'b1,1'b0,1'b0,8'h00},
        '{2'b01,1'b0,1'b1,1'b0,1'b0,1'b0,8'h11, 1'b0,1'b0,1'b0,1'b1,1'b0,8'h11},
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b1,8'h00, 1'b1,1'b1,1'b1,1'b0,1'b0,8'h00},
        '{2'b01,1'b1,1'b0,1'b0,1'b1,1'b0,8'h22, 1'b1,1'b1,1'b0,1'b1,1'b0,8'h22},
        '{2'b01,1'b1,1'b0,1'b1,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,8'h00},
        '{2'b01,1'b1,1'b0,1'b0,1'b1,1'b0,8'h33, 1'b1,1'b1,1'b0,1'b1,1'b0,8'h33},
        '{2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,8'h00}
    };

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        host_wr = 1'b0; host_rd = 1'b0; dsk_push = 1'b0; dsk_pop = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        quiet();
        phase = 2'b11;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic configure(input logic en, input logic [3:0] code);
        cfg_we = 1'b1; cfg_fifo_en = en; cfg_thr_code = code;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "q_empty", 8'(q_empty), 8'h1);
        chk("R1", "q_full", 8'(q_full), 8'h0);
        chk("R1", "rqm", 8'(rqm), 8'h0);
        chk("R1", "dma_req", 8'(dma_req), 8'h0);
        chk("R1", "xfer_err", 8'(xfer_err), 8'h0);

        // table walk, byte mode
        for (int i = 0; i < 12; i++) begin
            phase = VEC[i].ph; exec_to_host = VEC[i].x2h;
            host_wr = VEC[i].hwr; host_rd = VEC[i].hrd;
            dsk_push = VEC[i].dpush; dsk_pop = VEC[i].dpop;
            host_wdata = VEC[i].din; dsk_wdata = VEC[i].din;
            step();
            quiet();
            chk("R6", $sformatf("v%0d rqm", i), 8'(rqm), 8'(VEC[i].rqm));
            chk("R7", $sformatf("v%0d dma_req", i), 8'(dma_req), 8'(VEC[i].dreq));
            chk("R2", $sformatf("v%0d q_empty", i), 8'(q_empty), 8'(VEC[i].emp));
            chk("R2", $sformatf("v%0d q_full", i), 8'(q_full), 8'(VEC[i].ful));
            chk("R9", $sformatf("v%0d xfer_err", i), 8'(xfer_err), 8'(VEC[i].err));
            if (!VEC[i].emp) chk("R11", $sformatf("v%0d head", i), host_rdata, VEC[i].head);
        end

        // R3 R5 R7 burst host-to-disk, threshold 4
        phase = 2'b11;
        configure(1'b1, 4'd3);
        phase = 2'b01; exec_to_host = 1'b0;
        step();
        chk("R7", "burst wr dreq at empty", 8'(dma_req), 8'h1);
        for (int k = 0; k < 16; k++) begin
            host_wr = 1'b1; host_wdata = 8'h40 + 8'(k);
            step();
            quiet();
            chk("R5", $sformatf("fill %0d q_full", k), 8'(q_full), 8'(k == 15));
            chk("R6", $sformatf("fill %0d rqm", k), 8'(rqm), 8'(k != 15));
            chk("R7", $sformatf("fill %0d dreq", k), 8'(dma_req), 8'(k != 15));
        end
        for (int k = 0; k < 16; k++) begin
            chk("R11", $sformatf("drain %0d order", k), dsk_rdata, 8'h40 + 8'(k));
            dsk_pop = 1'b1;
            step();
            quiet();
            chk("R7", $sformatf("drain %0d dreq hold", k), 8'(dma_req), 8'((15 - k) <= 12));
        end
        chk("R5", "drained empty", 8'(q_empty), 8'h1);

        // R8 flush of residual burst contents
        for (int k = 0; k < 5; k++) begin
            host_wr = 1'b1; host_wdata = 8'(k);
            step();
        end
        quiet();
        chk("R8", "residual held", 8'(q_empty), 8'h0);
        phase = 2'b11;
        step();
        chk("R8", "flushed q_empty", 8'(q_empty), 8'h1);
        chk("R7", "dreq off outside exec", 8'(dma_req), 8'h0);

        // R7 burst disk-to-host, threshold 4, hold until empty
        phase = 2'b01; exec_to_host = 1'b1;
        for (int k = 0; k < 6; k++) begin
            dsk_push = 1'b1; dsk_wdata = 8'h90 + 8'(k);
            step();
            quiet();
            chk("R7", $sformatf("rd fill %0d dreq", k), 8'(dma_req), 8'(k >= 3));
        end
        for (int k = 0; k < 6; k++) begin
            chk("R11", $sformatf("host order %0d", k), host_rdata, 8'h90 + 8'(k));
            host_rd = 1'b1;
            step();
            quiet();
            chk("R7", $sformatf("rd drain %0d dreq", k), 8'(dma_req), 8'(k != 5));
        end

        // R4 command phase stays single-byte with queuing on; R9 overrun
        phase = 2'b00;
        step();
        host_wr = 1'b1; host_wdata = 8'hC1;
        step();
        chk("R4", "cmd one byte full", 8'(q_full), 8'h1);
        host_wdata = 8'hC2;
        step();
        quiet();
        chk("R9", "cmd overrun err", 8'(xfer_err), 8'h1);
        chk("R9", "overrun kept byte", host_rdata, 8'hC1);
        dsk_pop = 1'b1;
        step();
        quiet();
        chk("R9", "overrun left no extra", 8'(q_empty), 8'h1);
        phase = 2'b10;
        step();
        chk("R9", "err sticky", 8'(xfer_err), 8'h1);
        do_reset();
        chk("R1", "reset clears err", 8'(xfer_err), 8'h0);

        // R3 threshold 16 boundary, disk-to-host; R9 underrun
        configure(1'b1, 4'd15);
        phase = 2'b01; exec_to_host = 1'b1;
        for (int k = 0; k < 16; k++) begin
            dsk_push = 1'b1; dsk_wdata = 8'(k);
            step();
            quiet();
            chk("R3", $sformatf("thr16 fill %0d dreq", k), 8'(dma_req), 8'(k == 15));
        end
        for (int k = 0; k < 16; k++) begin
            host_rd = 1'b1;
            step();
        end
        quiet();
        chk("R9", "no err before underrun", 8'(xfer_err), 8'h0);
        host_rd = 1'b1;
        step();
        quiet();
        chk("R9", "underrun err", 8'(xfer_err), 8'h1);
        chk("R7", "dreq clear empty", 8'(dma_req), 8'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule